// File: doc/BRIEF.md
# Supply Trim Pulse Controller

This block closes the loop on the output voltage of one supply channel. It works by dropping short, fixed-width charge pulses onto an external hold capacitor, whose buffered voltage steers the converter's trim input. A timer advances on a 1 MHz tick enable and defines a long correction period. At the first tick of each period the block reads two comparator flags, one saying whether the supply sits above its target and one saying whether it sits inside the target window. From these it chooses to source charge, sink charge or do nothing for that period.

Each channel has its own enable. While the channel is enabled but the power-up sequencer has not yet reported that every sequenced rail passed its first undervoltage threshold, the block leaves the trim node undriven and asks the buffer to copy the converter's own output level onto the capacitor. When closed-loop control takes over, the capacitor therefore already holds the present level, and the hand-over causes no step. When trimming is disabled, the node is left in high impedance and no tracking takes place. An optional boost selects a pulse ten times stronger. Boost applies only until the supply first lands in the target window. That event also raises a sticky at-nominal flag, which remains set for as long as control stays active.

Top module: `supply_trim_ctrl`

## Requirements
- R1: While active, a correction opportunity recurs every PERIOD_TICKS ticks (default 1700), so successive pulse rising edges are PERIOD_TICKS tick periods apart.
- R2: Each pulse stays high for exactly WIDTH_TICKS ticks (default 5). With a tick on every clock this is 5 clock cycles, and it begins the cycle after the sampling tick.
- R3: At the first tick of a period, above_tgt_i=1 with at_tgt_i=0 yields a sink pulse, and above_tgt_i=0 with at_tgt_i=0 yields a source pulse. A flag change after that sampling tick does not alter the pulse already running.
- R4: If at_tgt_i=1 at the sampling tick, neither pulse output rises during that period.
- R5: src_pulse_o and snk_pulse_o are never high in the same cycle, and neither is ever high while drive_en_o is low.
- R6: With trim_en_i=0, from the next clock onward drive_en_o, track_o, both pulse outputs, boost_o and nominal_o are all 0, whatever seq_done_i does.
- R7: With trim_en_i=1 and seq_done_i=0, from the next clock track_o=1 and drive_en_o=0. Clearing seq_done_i while active returns the block to tracking on the next clock.
- R8: drive_en_o rises on the clock after trim_en_i and seq_done_i are both 1. The period timer restarts at that point, so with a tick present the first pulse rises one cycle after drive_en_o.
- R9: nominal_o rises the cycle after a sampling tick that sees at_tgt_i=1. It then stays high while the block remains active, even if the supply leaves the window, and it clears when the block leaves the active state.
- R10: boost_o is high while active when speedup_en_i is set (registered, one-cycle delay) and nominal has not yet been reached. After nominal_o rises, boost_o stays low until the block leaves the active state.
- R11: The period and width counters advance only on cycles where tick_i=1. With a tick every second clock, a pulse lasts 2*WIDTH_TICKS cycles and the period is 2*PERIOD_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 MHz timing enable |
| trim_en_i | input | 1 | Channel trim enable |
| speedup_en_i | input | 1 | Request for tenfold pulse strength until nominal |
| seq_done_i | input | 1 | Level from the sequencer: all sequenced rails above their first threshold |
| above_tgt_i | input | 1 | Comparator flag: supply above target |
| at_tgt_i | input | 1 | Comparator flag: supply inside target window |
| src_pulse_o | output | 1 | Source charge pulse (raise supply) |
| snk_pulse_o | output | 1 | Sink charge pulse (lower supply) |
| drive_en_o | output | 1 | Trim node driven; 0 means high impedance |
| track_o | output | 1 | Buffer copies converter output onto the capacitor |
| boost_o | output | 1 | Pulse magnitude select: 1 = tenfold |
| nominal_o | output | 1 | Supply has reached its set point |

## Verification
The assertions assume that WIDTH_TICKS is at least 2 and that the comparator flags are never both high. A supply cannot be above target and inside the window at the same time, so the bench drives only the three legal flag combinations. The bench drives every input on the falling clock edge, and tick_i is either held high or toggled every cycle, so it is always a clean single-cycle enable. Flags are changed both between periods and in the middle of a running pulse. This exercises the rule that direction is sampled once per period without ever showing the block a contradictory comparator pair.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_TRACK  = 2'd1,
        MODE_ACTIVE = 2'd2
    } trim_mode_e;

endpackage

// File: rtl/trim_mode_ctrl.sv
module trim_mode_ctrl
    import trim_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       trim_en_i,
    input  logic       seq_done_i,
    output trim_mode_e mode_o
);

    typedef struct packed {
        trim_mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!trim_en_i) begin
            st_d.mode = MODE_OFF;
        end else if (seq_done_i) begin
            st_d.mode = MODE_ACTIVE;
        end else begin
            st_d.mode = MODE_TRACK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/trim_period_timer.sv
module trim_period_timer #(
    parameter int PERIOD_TICKS = 1700
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic tick_i,
    output logic sample_o
);

    localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // first tick of every period is the sampling instant
    assign sample_o = active_i && tick_i && (st_q.cnt == '0);

endmodule

// File: rtl/trim_pulse_gen.sv
module trim_pulse_gen #(
    parameter int WIDTH_TICKS = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic tick_i,
    input  logic sample_i,
    input  logic above_i,
    input  logic at_i,
    input  logic speedup_i,
    output logic src_o,
    output logic snk_o,
    output logic reached_o,
    output logic speedup_o
);

    localparam int WID_W = $clog2(WIDTH_TICKS + 1);
    localparam logic [WID_W-1:0] WID_LOAD = WID_W'(WIDTH_TICKS - 1);

    typedef struct packed {
        logic             src;
        logic             snk;
        logic             reached;
        logic             spd;
        logic [WID_W-1:0] wid;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.spd = speedup_i;
        if (!active_i) begin
            st_d.src     = 1'b0;
            st_d.snk     = 1'b0;
            st_d.wid     = '0;
            st_d.reached = 1'b0;
        end else if (sample_i) begin
            st_d.wid = WID_LOAD;
            if (at_i) begin
                st_d.src     = 1'b0;
                st_d.snk     = 1'b0;
                st_d.reached = 1'b1;
            end else begin
                st_d.src = !above_i;
                st_d.snk = above_i;
            end
        end else if (tick_i && (st_q.src || st_q.snk)) begin
            if (st_q.wid == '0) begin
                st_d.src = 1'b0;
                st_d.snk = 1'b0;
            end else begin
                st_d.wid = st_q.wid - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{src: 1'b0, snk: 1'b0, reached: 1'b0, spd: 1'b0, wid: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o     = st_q.src;
    assign snk_o     = st_q.snk;
    assign reached_o = st_q.reached;
    assign speedup_o = st_q.spd;

endmodule

// File: rtl/supply_trim_ctrl.sv
module supply_trim_ctrl
    import trim_pkg::*;
#(
    parameter int PERIOD_TICKS = 1700,
    parameter int WIDTH_TICKS  = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic trim_en_i,
    input  logic speedup_en_i,
    input  logic seq_done_i,
    input  logic above_tgt_i,
    input  logic at_tgt_i,
    output logic src_pulse_o,
    output logic snk_pulse_o,
    output logic drive_en_o,
    output logic track_o,
    output logic boost_o,
    output logic nominal_o
);

    trim_mode_e mode;
    logic       active;
    logic       sample;
    logic       src_raw;
    logic       snk_raw;
    logic       reached;
    logic       spd;

    trim_mode_ctrl u_mode (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trim_en_i  (trim_en_i),
        .seq_done_i (seq_done_i),
        .mode_o     (mode)
    );

    assign active = (mode == MODE_ACTIVE);

    trim_period_timer #(
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .tick_i   (tick_i),
        .sample_o (sample)
    );

    trim_pulse_gen #(
        .WIDTH_TICKS (WIDTH_TICKS)
    ) u_pulse (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (active),
        .tick_i    (tick_i),
        .sample_i  (sample),
        .above_i   (above_tgt_i),
        .at_i      (at_tgt_i),
        .speedup_i (speedup_en_i),
        .src_o     (src_raw),
        .snk_o     (snk_raw),
        .reached_o (reached),
        .speedup_o (spd)
    );

    // pulses are gated by the drive state so a pulse never leaves a floating node
    assign src_pulse_o = src_raw && active;
    assign snk_pulse_o = snk_raw && active;
    assign drive_en_o  = active;
    assign track_o     = (mode == MODE_TRACK);
    assign boost_o     = active && spd && !reached;
    assign nominal_o   = active && reached;

endmodule

// File: rtl/supply_trim_ctrl_chk.sv
module supply_trim_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic trim_en_i,
    input logic seq_done_i,
    input logic src_pulse_o,
    input logic snk_pulse_o,
    input logic drive_en_o,
    input logic track_o,
    input logic boost_o,
    input logic nominal_o
);

    // R5
    dir_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(src_pulse_o && snk_pulse_o));

    // R5
    pulse_needs_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_pulse_o || snk_pulse_o) |-> drive_en_o);

    // R6
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trim_en_i |=> (!drive_en_o && !track_o && !nominal_o && !boost_o));

    // R7
    track_before_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_en_i && !seq_done_i) |=> (track_o && !drive_en_o));

    // R9
    nominal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nominal_o && trim_en_i && seq_done_i) |=> nominal_o);

    // R10
    boost_off_at_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nominal_o |-> !boost_o);

    // R2
    src_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(src_pulse_o) |=> (src_pulse_o || !drive_en_o));

endmodule

bind supply_trim_ctrl supply_trim_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trim_en_i   (trim_en_i),
    .seq_done_i  (seq_done_i),
    .src_pulse_o (src_pulse_o),
    .snk_pulse_o (snk_pulse_o),
    .drive_en_o  (drive_en_o),
    .track_o     (track_o),
    .boost_o     (boost_o),
    .nominal_o   (nominal_o)
);

// File: tb/supply_trim_ctrl_tb_top.sv
module supply_trim_ctrl_tb_top;

    localparam int P = 1700;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic trim_en = 1'b0;
    logic speedup = 1'b0;
    logic seq_done = 1'b0;
    logic above = 1'b0;
    logic at = 1'b0;
    logic src, snk, drv, trk, bst, nom;

    int tick_mode = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    supply_trim_ctrl #(.PERIOD_TICKS(P), .WIDTH_TICKS(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .trim_en_i(trim_en),
        .speedup_en_i(speedup), .seq_done_i(seq_done), .above_tgt_i(above),
        .at_tgt_i(at), .src_pulse_o(src), .snk_pulse_o(snk), .drive_en_o(drv),
        .track_o(trk), .boost_o(bst), .nominal_o(nom)
    );

    // behavioural reference
    int m_on = 0, m_trk = 0, m_per = 0, m_left = 0, m_dir = 0; // dir: 0 none, 1 src, 2 snk
    int m_nom = 0, m_spd = 0;

    always @(posedge clk) begin
        int on_n, trk_n, per_n, left_n, dir_n, nom_n;
        bit smp;
        if (!rst_n) begin
            m_on = 0; m_trk = 0; m_per = 0; m_left = 0; m_dir = 0; m_nom = 0; m_spd = 0;
        end else begin
            smp    = (m_on != 0) && tick && (m_per == 0);
            on_n   = (trim_en && seq_done) ? 1 : 0;
            trk_n  = (trim_en && !seq_done) ? 1 : 0;
            per_n  = (m_on == 0) ? 0 : (tick ? (m_per + 1) % P : m_per);
            left_n = m_left; dir_n = m_dir; nom_n = m_nom;
            if (m_on == 0) begin
                left_n = 0; dir_n = 0; nom_n = 0;
            end else if (smp) begin
                left_n = W;
                if (at) begin dir_n = 0; nom_n = 1; end
                else dir_n = above ? 2 : 1;
            end else if (tick && m_dir != 0) begin
                left_n = m_left - 1;
                if (left_n == 0) dir_n = 0;
            end
            m_spd = speedup ? 1 : 0;
            m_on = on_n; m_trk = trk_n; m_per = per_n; m_left = left_n; m_dir = dir_n; m_nom = nom_n;
        end
    end

    task automatic chk(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
        end
    endtask

    // pulse monitor
    int any_cnt = 0, src_cnt = 0, snk_cnt = 0;
    int last_rise = -1, last_period = 0, last_width = 0, drv_rise = -1, first_gap = -1;
    bit prev_any = 0, prev_src = 0, prev_snk = 0, prev_drv = 0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            // every-cycle comparison against the reference
            chk("R5 src_pulse", src, (m_on != 0 && m_dir == 1) ? 1 : 0);
            chk("R3 snk_pulse", snk, (m_on != 0 && m_dir == 2) ? 1 : 0);
            chk("R8 drive_en", drv, m_on);
            chk("R7 track", trk, m_trk);
            chk("R10 boost", bst, (m_on != 0 && m_spd != 0 && m_nom == 0) ? 1 : 0);
            chk("R9 nominal", nom, (m_on != 0 && m_nom != 0) ? 1 : 0);
            if (drv && !prev_drv) drv_rise = cyc;
            if ((src || snk) && !prev_any) begin
                any_cnt++;
                if (last_rise >= 0) last_period = cyc - last_rise;
                if (first_gap < 0 && drv_rise >= 0) first_gap = cyc - drv_rise;
                last_rise = cyc;
            end
            if (!(src || snk) && prev_any) last_width = cyc - last_rise;
            if (src && !prev_src) src_cnt++;
            if (snk && !prev_snk) snk_cnt++;
            prev_any = src || snk; prev_src = src; prev_snk = snk; prev_drv = drv;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            tick <= (tick_mode == 0) ? 1'b1 : ~tick;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int snap;

    initial begin
        wait_cyc(4);
        rst_n <= 1'b1;
        wait_cyc(2);
        chk("R6 reset drive_en", drv, 0);
        chk("R6 reset track", trk, 0);
        chk("R9 reset nominal", nom, 0);

        // disabled, sequencer done
        seq_done <= 1'b1;
        wait_cyc(50);
        chk("R6 disabled drive_en", drv, 0);
        chk("R6 disabled pulses", any_cnt, 0);

        // enabled, waiting for sequencer
        seq_done <= 1'b0; trim_en <= 1'b1;
        wait_cyc(20);
        chk("R7 tracking", trk, 1);
        chk("R7 undriven", drv, 0);

        // activate with boost, supply low
        speedup <= 1'b1; above <= 1'b0; at <= 1'b0; seq_done <= 1'b1;
        wait_cyc(3 * P + 20);
        chk("R8 first pulse gap", first_gap, 1);
        chk("R3 source only", snk_cnt, 0);
        chk("R3 source count", src_cnt, 4);
        chk("R2 width", last_width, W);
        chk("R1 period", last_period, P);
        chk("R10 boost before nominal", bst, 1);

        // flip direction in the middle of a source pulse
        wait (src == 1'b1);
        @(negedge clk);
        above <= 1'b1;
        wait_cyc(W + 3);
        chk("R3 running pulse keeps width", last_width, W);
        chk("R3 no sink yet", snk_cnt, 0);
        wait_cyc(P);
        chk("R3 sink after resample", snk_cnt, 1);

        // reach target
        above <= 1'b0; at <= 1'b1;
        wait_cyc(P + 10);
        chk("R9 nominal raised", nom, 1);
        chk("R10 boost dropped", bst, 0);
        snap = any_cnt;
        wait_cyc(P);
        chk("R4 no pulse in window", any_cnt, snap);

        // leave target; flag sticky, boost stays off
        at <= 1'b0; above <= 1'b1;
        wait_cyc(P + 10);
        chk("R9 nominal sticky", nom, 1);
        chk("R10 boost stays off", bst, 0);
        chk("R4 pulses resume", (any_cnt > snap) ? 1 : 0, 1);

        // half-rate tick
        tick_mode = 1;
        wait_cyc(3 * 2 * P + 30);
        chk("R11 width on half-rate tick", last_width, 2 * W);
        chk("R11 period on half-rate tick", last_period, 2 * P);

        // sequencer withdraws
        seq_done <= 1'b0;
        wait_cyc(2);
        chk("R7 back to tracking", trk, 1);
        chk("R7 undriven again", drv, 0);
        chk("R9 nominal cleared", nom, 0);

        trim_en <= 1'b0;
        wait_cyc(2);
        chk("R6 disabled track", trk, 0);
        chk("R6 disabled boost", bst, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule